// File: doc/BRIEF.md
# Latched 64-bit Free-Running Counter

The block holds a 64-bit up-counter that advances by one on every clock, starting from a parameter value after reset. Software never reads the running counter directly. It reads a pair of 32-bit snapshot words and a small control register. A software request copies the whole counter into both snapshot words on the same clock edge. A read of the low word followed by a read of the high word then returns one coherent value, even when a carry crosses the word boundary between the two reads.

A second request bit zeroes both the running counter and the snapshot words. Both request bits clear themselves one clock after they are written. Software may also write either snapshot word directly. The register port is a plain synchronous bus. A write takes effect on the clock edge that samples it. Read data is registered and appears one clock after the read strobe.

Top module: `snap_counter_top`

## Requirements
- R1: The running counter loads CNT_INIT (default 0) in reset and then rises by exactly one on every clock edge. A carry out of bit 31 reaches bit 32 on the same edge.
- R2: Register addresses are: 0 for control, 1 for the snapshot bits [31:0], and 2 for the snapshot bits [63:32]. In control, bit 1 requests a latch and bit 0 requests a clear.
- R3: When rd_en is sampled high, rd_data carries the addressed register from the following edge onward. When rd_en is low, rd_data holds its value. Reading address 3 returns zero.
- R4: A control write with bit 1 set has its effect one edge later. On that edge both snapshot words take the value the running counter held in the cycle after the write.
- R5: A request bit that is written as 1 reads back as 1 only in the cycle right after the write. From the next edge it reads as 0, unless a new control write arrives.
- R6: A control write with bit 0 set zeroes both snapshot words and the running counter one edge later. Counting then resumes from zero.
- R7: A control write with bits 1 and 0 both set leaves both snapshot words at zero. The running counter is also zeroed.
- R8: After reset, control and both snapshot words read as zero.
- R9: A write to address 1 or 2 replaces that snapshot word on the next edge. The other word and the running counter are not affected.
- R10: A pending latch or clear action takes precedence over a direct snapshot-word write on the same edge. That word write is dropped.
- R11: Control bits 31 to 2 are ignored. A control write with bits 1 and 0 both clear triggers no action, and control reads back as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (2) | Register address |
| wdata | input | DATA_W (32) | Write data |
| rd_data | output | DATA_W (32) | Registered read data |

## Verification
A control write sets the request register on its own edge. The latch or clear acts on the next edge. A read strobed in the cycle after that sees the result on the edge that follows, so snapshot data is first readable two edges after the request write. Read data always lands one edge after the strobe. The bench advances a behavioural model on every rising edge using the same sampled inputs. It compares rd_data against that model at every falling edge, so each result is checked in exactly the cycle it is due. Hard-coded expected values back up the model at the carry, clear, direct-write and self-clear points.

// File: rtl/snap_pkg.sv
package snap_pkg;
  localparam int unsigned CTRL_ADDR = 0;
  localparam int unsigned CLR_BIT   = 0;
  localparam int unsigned LATCH_BIT = 1;
  localparam int unsigned CTRL_W    = 2;

  typedef logic [CTRL_W-1:0] ctrl_req_t;
endpackage

// File: rtl/snap_free_counter.sv
module snap_free_counter #(
  parameter int unsigned     CNT_W    = 64,
  parameter logic [CNT_W-1:0] CNT_INIT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= CNT_INIT;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + CNT_W'(1);
  end

  assign count_o = cnt_q;

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> count_o == $past(count_o) + CNT_W'(1));

  // R6
  count_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> count_o == '0);
endmodule

// File: rtl/snap_ctrl_reg.sv
module snap_ctrl_reg
  import snap_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_i,
  input  ctrl_req_t bits_i,
  output ctrl_req_t req_o
);
  ctrl_req_t req_q;

  always_ff @(posedge clk) begin
    if (rst)       req_q <= '0;
    else if (wr_i) req_q <= bits_i;
    else           req_q <= '0;
  end

  assign req_o = req_q;

  // R5
  self_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (req_o != '0 && !wr_i) |=> req_o == '0);
endmodule

// File: rtl/snap_shadow.sv
module snap_shadow #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORDS  = 2,
  localparam int unsigned CNT_W = DATA_W * WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              latch_i,
  input  logic              clr_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [WORDS-1:0]  wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  words_o
);
  for (genvar k = 0; k < WORDS; k++) begin : g_word
    logic [DATA_W-1:0] w_q;
    always_ff @(posedge clk) begin
      if (rst)          w_q <= '0;
      else if (clr_i)   w_q <= '0;
      else if (latch_i) w_q <= count_i[k*DATA_W +: DATA_W];
      else if (wr_i[k]) w_q <= wdata_i;
    end
    assign words_o[k*DATA_W +: DATA_W] = w_q;
  end

  // R4
  latch_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (latch_i && !clr_i) |=> words_o == $past(count_i));

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> words_o == '0);

  // R9
  low_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_i[0] && !latch_i && !clr_i) |=> words_o[DATA_W-1:0] == $past(wdata_i));
endmodule

// File: rtl/snap_read_mux.sv
module snap_read_mux
  import snap_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORDS  = 2,
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned CNT_W = DATA_W * WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  ctrl_req_t         ctrl_i,
  input  logic [CNT_W-1:0]  words_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] sel;
  logic [DATA_W-1:0] rd_q;

  always_comb begin
    sel = '0;
    if (addr_i == ADDR_W'(CTRL_ADDR)) sel = {{(DATA_W-CTRL_W){1'b0}}, ctrl_i};
    for (int k = 0; k < WORDS; k++) begin
      if (addr_i == ADDR_W'(k + 1)) sel = words_i[k*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rd_q <= '0;
    else if (rd_en_i) rd_q <= sel;
  end

  assign rd_data_o = rd_q;

  // R3
  read_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/snap_counter_top.sv
module snap_counter_top
  import snap_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORDS  = 2,
  parameter int unsigned ADDR_W = 2,
  parameter logic [DATA_W*WORDS-1:0] CNT_INIT = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned CNT_W = DATA_W * WORDS;

  logic             wr_ctrl;
  logic [WORDS-1:0] wr_word;
  ctrl_req_t        req;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] words;

  assign wr_ctrl = wr_en && (addr == ADDR_W'(CTRL_ADDR));
  for (genvar k = 0; k < WORDS; k++) begin : g_dec
    assign wr_word[k] = wr_en && (addr == ADDR_W'(k + 1));
  end

  snap_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wr_i   (wr_ctrl),
    .bits_i (wdata[CTRL_W-1:0]),
    .req_o  (req)
  );

  snap_free_counter #(.CNT_W(CNT_W), .CNT_INIT(CNT_INIT)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (req[CLR_BIT]),
    .count_o (count)
  );

  snap_shadow #(.DATA_W(DATA_W), .WORDS(WORDS)) u_shadow (
    .clk     (clk),
    .rst     (rst),
    .latch_i (req[LATCH_BIT]),
    .clr_i   (req[CLR_BIT]),
    .count_i (count),
    .wr_i    (wr_word),
    .wdata_i (wdata),
    .words_o (words)
  );

  snap_read_mux #(.DATA_W(DATA_W), .WORDS(WORDS), .ADDR_W(ADDR_W)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_en_i   (rd_en),
    .addr_i    (addr),
    .ctrl_i    (req),
    .words_i   (words),
    .rd_data_o (rd_data)
  );
endmodule

// File: tb/snap_counter_top_test.sv
module snap_counter_top_test;
  localparam logic [63:0] INIT = 64'h0000_0000_FFFF_FF00;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;

  int checks = 0, errors = 0, cycles = 0;
  string phase = "R8";

  always #10 clk = ~clk;

  snap_counter_top #(.CNT_INIT(INIT)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rd_data(rd_data)
  );

  // behavioural reference model
  logic [63:0] m_cnt, m_old;
  logic [1:0]  m_ctl, m_act;
  logic [31:0] m_lo, m_hi, m_rd, m_sel;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_cnt = INIT; m_ctl = 0; m_lo = 0; m_hi = 0; m_rd = 0;
    end else begin
      case (addr)
        2'd0: m_sel = {30'd0, m_ctl};
        2'd1: m_sel = m_lo;
        2'd2: m_sel = m_hi;
        default: m_sel = 0;
      endcase
      m_act = m_ctl;
      m_ctl = (wr_en && addr == 2'd0) ? wdata[1:0] : 2'b00;
      m_old = m_cnt;
      m_cnt = m_act[0] ? 64'd0 : m_cnt + 64'd1;
      if (m_act != 0) begin
        if (m_act[1]) {m_hi, m_lo} = m_old;
        if (m_act[0]) {m_hi, m_lo} = 64'd0;
      end else if (wr_en && addr == 2'd1) m_lo = wdata;
      else if (wr_en && addr == 2'd2) m_hi = wdata;
      if (rd_en) m_rd = m_sel;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst) check(phase, rd_data, m_rd);

  always @(posedge clk) if (cycles > 100000) begin
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; rd_en = 0; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    phase = tag;
    @(negedge clk); rd_en = 1; wr_en = 0; addr = a;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic rd_exp(input logic [1:0] a, input logic [31:0] exp, input string tag);
    rd(a, tag);
    check(tag, rd_data, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    @(negedge clk); rst = 0;
    // R8 reset values
    rd_exp(2'd0, 32'd0, "R8");
    rd_exp(2'd1, 32'd0, "R8");
    rd_exp(2'd2, 32'd0, "R8");
    // R4 latch, R5 self-clear visible for one cycle
    phase = "R4";
    @(negedge clk); wr_en = 1; addr = 2'd0; wdata = 32'd2;
    @(negedge clk); wr_en = 0; rd_en = 1; addr = 2'd0;
    @(negedge clk); rd_en = 0;
    check("R5", rd_data, 32'd2);
    rd_exp(2'd0, 32'd0, "R5");
    rd(2'd1, "R4");
    rd_exp(2'd2, 32'd0, "R4");
    // R1 carry into the high word
    idle(300);
    wr(2'd0, 32'd2);
    rd_exp(2'd2, 32'd1, "R1");
    rd(2'd1, "R1");
    // R6 clear
    wr(2'd0, 32'd1);
    rd_exp(2'd1, 32'd0, "R6");
    rd_exp(2'd2, 32'd0, "R6");
    idle(10);
    wr(2'd0, 32'd2);
    rd_exp(2'd2, 32'd0, "R6");
    rd(2'd1, "R6");
    // R7 latch and clear together
    wr(2'd0, 32'd3);
    rd_exp(2'd1, 32'd0, "R7");
    rd_exp(2'd2, 32'd0, "R7");
    // R9 direct word writes
    wr(2'd1, 32'hDEAD_BEEF);
    rd_exp(2'd1, 32'hDEAD_BEEF, "R9");
    rd_exp(2'd2, 32'd0, "R9");
    wr(2'd2, 32'h1234_5678);
    rd_exp(2'd2, 32'h1234_5678, "R9");
    rd_exp(2'd1, 32'hDEAD_BEEF, "R9");
    // R10 pending action beats a direct write
    phase = "R10";
    @(negedge clk); wr_en = 1; addr = 2'd0; wdata = 32'd1;
    @(negedge clk); addr = 2'd1; wdata = 32'hA5A5_A5A5;
    @(negedge clk); wr_en = 0;
    rd_exp(2'd1, 32'd0, "R10");
    // R11 upper control bits ignored
    wr(2'd1, 32'h0BAD_F00D);
    wr(2'd0, 32'hFFFF_FFFC);
    rd_exp(2'd0, 32'd0, "R11");
    rd_exp(2'd1, 32'h0BAD_F00D, "R11");
    // R3 unmapped address and read hold
    rd_exp(2'd3, 32'd0, "R3");
    phase = "R3";
    idle(5);
    check("R3", rd_data, 32'd0);
    // R2 mapping sanity through the model
    wr(2'd0, 32'd2);
    rd(2'd1, "R2");
    rd(2'd2, "R2");
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule